// File: doc/BRIEF.md
# Multichannel DAC Register and Control Bank

This block is the digital core that sits in front of a bank of 10-bit voltage-output converters. Each channel holds a double-buffered code path: a host write goes into the channel's data register, and the converter-facing DAC register takes that value only when a load happens. The load comes from an asynchronous active-low strobe. It is synchronised into the clock domain, and its falling edge updates every channel together. Each channel carries a 10-bit main code and a separate 8-bit trim code that shifts the transfer function around the bias point.

Control is split between one system register, which acts on all channels, and one control register per channel. The system register holds power-down, system standby, a self-clearing system clear and the input coding (offset binary or twos complement). Each channel register holds a channel standby, a self-clearing channel clear and a bias-source select. The block drives the converter-facing codes, the bias selects, per-channel enables and a reference enable. A hardware clear input returns every channel to its bias point.

Top module: `dacbank_core`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every channel outputs main code 0x200, trim code 0x80 and bias select 0, all channel enables and the reference enable are 1, and the coding is offset binary.
- R2: A data write changes only the channel's data register. main_code and trim_code do not change until a load or a clear.
- R3: When load_n falls, every channel's DAC registers (main and trim) take their data registers at the third rising edge that samples load_n low. Holding load_n low gives only one update, so a write made while it stays low is not loaded.
- R4: hw_clear high at a rising edge loads all channels' data and DAC registers so that, from that edge on, every main output is 0x200 and every trim output is 0x80.
- R5: Writing the system register with bit 2 set clears all channels, exactly as R4 does, at the next rising edge. The bit then clears itself, so later writes and loads take effect.
- R6: Writing a channel control register with bit 1 set clears only that channel, as R4 does, at the next rising edge. The bit clears itself.
- R7: System bit 3 selects twos complement. While it is set, main_code is the DAC register with bit 9 inverted. A clear in either coding leaves the main output at 0x200.
- R8: System bit 0 (power-down) drives ref_enable to 0 and every ch_enable bit to 0 from the edge of the write.
- R9: System bit 1 (standby) drives every ch_enable bit to 0 and leaves ref_enable at 1. Channel control bit 0 drives only that channel's ch_enable bit to 0.
- R10: Channel control bits [3:2] set the bias select from the edge of the write: 0 is half supply, 1 is the internal reference and 2 is the external reference. The value 3 is ignored and the field keeps its previous value.
- R11: wr_sel selects the target: 0 is the main data register (wr_data[9:0]), 1 is the trim data register (wr_data[7:0], upper bits ignored), 2 is the channel control register and 3 is the system register (wr_chan ignored).
- R12: A clear in the same cycle as a data write or a load takes precedence, and the written or loaded value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on reset) |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_chan | input | 2 | Channel address of the write |
| wr_sel | input | 2 | Register select (R11) |
| wr_data | input | 10 | Write data |
| load_n | input | 1 | Asynchronous active-low load strobe |
| hw_clear | input | 1 | Hardware clear, active high, sampled on the clock |
| main_code | output | 40 | Converter main codes, 10 bits per channel, channel 0 in the low bits |
| trim_code | output | 32 | Converter trim codes, 8 bits per channel |
| bias_sel | output | 8 | Bias-source selects, 2 bits per channel |
| ch_enable | output | 4 | Per-channel power enable |
| ref_enable | output | 1 | Reference power enable |

## Verification
Control writes, power-down, standby, bias and coding changes appear at the outputs after the rising edge that takes the write. A system or channel clear appears one edge later, and hw_clear appears after the edge that samples it. A load appears after the third rising edge that samples load_n low. The bench drives inputs on falling edges and updates a behavioural model on every rising edge. It compares all outputs at each falling edge, so every result is checked in the cycle it is due. Directed checks wait the matching number of falling edges before they sample.

// File: rtl/dacbank_pkg.sv
// Shared encodings for the DAC register bank.
// Assumes: the register select field is 2 bits wide and the bias field is 2 bits wide.
package dacbank_pkg;

    typedef enum logic [1:0] {
        SEL_MAIN = 2'd0,
        SEL_TRIM = 2'd1,
        SEL_CHAN = 2'd2,
        SEL_SYS  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BIAS_HALF   = 2'd0,
        BIAS_INTREF = 2'd1,
        BIAS_EXTREF = 2'd2,
        BIAS_NONE   = 2'd3
    } bias_e;

    // Bit positions inside the control words
    localparam int CB_STBY = 0;
    localparam int CB_CLR  = 1;
    localparam int CB_BLO  = 2;
    localparam int SB_PD   = 0;
    localparam int SB_STBY = 1;
    localparam int SB_CLR  = 2;
    localparam int SB_TWOS = 3;

endpackage

// File: rtl/dacbank_ldsync.sv
// Synchronises the asynchronous active-low load strobe and emits a one-cycle
// pulse per falling edge.
// Assumes: load_n is held low for at least two clock periods.
module dacbank_ldsync (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    output logic load_pulse
);
    logic [2:0] sync_q;

    // Two-flop synchroniser followed by a history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], load_n};
    end

    assign load_pulse = sync_q[2] & ~sync_q[1];

    // R3: one falling edge gives exactly one update pulse
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);

endmodule

// File: rtl/dacbank_sysctl.sv
// System control register: power-down, system standby, self-clearing system
// clear and input coding.
// Assumes: sys_we is a single-cycle strobe from the top-level decoder.
module dacbank_sysctl
    import dacbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_we,
    input  logic [3:0] sys_data,
    output logic       pwr_down,
    output logic       sys_stby,
    output logic       sys_clr_pend,
    output logic       twos
);
    // Holds the system control bits; the clear bit lives for one cycle only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down     <= 1'b0;
            sys_stby     <= 1'b0;
            sys_clr_pend <= 1'b0;
            twos         <= 1'b0;
        end else begin
            sys_clr_pend <= sys_we & sys_data[SB_CLR];
            if (sys_we) begin
                pwr_down <= sys_data[SB_PD];
                sys_stby <= sys_data[SB_STBY];
                twos     <= sys_data[SB_TWOS];
            end
        end
    end

    // R5: the system clear bit drops by itself unless rewritten
    assert_sysclr_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_clr_pend && !sys_we) |=> !sys_clr_pend);

endmodule

// File: rtl/dacbank_chan.sv
// One channel: double-buffered main and trim codes, channel control register
// (standby, self-clearing clear, bias select) and output coding.
// Assumes: MAIN_W >= 4 so that the control bits fit in the write word.
module dacbank_chan
    import dacbank_pkg::*;
#(
    parameter int MAIN_W = 10,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_we,
    input  logic              trim_we,
    input  logic              ctrl_we,
    input  logic [MAIN_W-1:0] wr_data,
    input  logic              load_pulse,
    input  logic              glob_clr,
    input  logic              twos,
    output logic [MAIN_W-1:0] main_code,
    output logic [TRIM_W-1:0] trim_code,
    output logic [1:0]        bias_sel,
    output logic              stby
);
    localparam logic [MAIN_W-1:0] MAIN_MID = MAIN_W'(1) << (MAIN_W - 1);
    localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);

    logic [MAIN_W-1:0] data_main, dac_main;
    logic [TRIM_W-1:0] data_trim, dac_trim;
    logic              clr_pend;
    logic              clr_now;
    logic [MAIN_W-1:0] clr_main;

    assign clr_now  = glob_clr | clr_pend;
    // Register value that maps to an output at the bias point in the current coding
    assign clr_main = twos ? '0 : MAIN_MID;

    // Channel control register with self-clearing clear bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby     <= 1'b0;
            clr_pend <= 1'b0;
            bias_sel <= BIAS_HALF;
        end else begin
            clr_pend <= ctrl_we & wr_data[CB_CLR];
            if (ctrl_we) begin
                stby <= wr_data[CB_STBY];
                if (wr_data[CB_BLO+1:CB_BLO] != BIAS_NONE)
                    bias_sel <= wr_data[CB_BLO+1:CB_BLO];
            end
        end
    end

    // Double buffer: clear first, else load and host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_main <= MAIN_MID;
            dac_main  <= MAIN_MID;
            data_trim <= TRIM_MID;
            dac_trim  <= TRIM_MID;
        end else if (clr_now) begin
            data_main <= clr_main;
            dac_main  <= clr_main;
            data_trim <= TRIM_MID;
            dac_trim  <= TRIM_MID;
        end else begin
            if (load_pulse) begin
                dac_main <= data_main;
                dac_trim <= data_trim;
            end
            if (main_we) data_main <= wr_data;
            if (trim_we) data_trim <= wr_data[TRIM_W-1:0];
        end
    end

    assign main_code = {dac_main[MAIN_W-1] ^ twos, dac_main[MAIN_W-2:0]};
    assign trim_code = dac_trim;

    // R3: a load copies the data register
    assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !clr_now) |=> (dac_main == $past(data_main)) && (dac_trim == $past(data_trim)));

    // R2: without load or clear the DAC register holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_pulse && !clr_now) |=> $stable(dac_main) && $stable(dac_trim));

    // R4/R12: a clear wins and lands on midscale
    assert_clear_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (dac_main == ($past(twos) ? '0 : MAIN_MID)) && (dac_trim == TRIM_MID));

    // R6: channel clear bit drops by itself unless rewritten
    assert_chclr_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !ctrl_we) |=> !clr_pend);

endmodule

// File: rtl/dacbank_core.sv
// Top of the DAC register bank: host write decode, load-strobe synchroniser,
// system register and N_CH channel slices; derives power enables.
// Assumes: wr_en is a one-cycle strobe in the clk domain; hw_clear is synchronous.
module dacbank_core
    import dacbank_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int MAIN_W = 10,
    parameter int TRIM_W = 8,
    localparam int CH_AW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_AW-1:0]         wr_chan,
    input  logic [1:0]               wr_sel,
    input  logic [MAIN_W-1:0]        wr_data,
    input  logic                     load_n,
    input  logic                     hw_clear,
    output logic [N_CH*MAIN_W-1:0]   main_code,
    output logic [N_CH*TRIM_W-1:0]   trim_code,
    output logic [N_CH*2-1:0]        bias_sel,
    output logic [N_CH-1:0]          ch_enable,
    output logic                     ref_enable
);
    logic load_pulse;
    logic pwr_down, sys_stby, sys_clr_pend, twos;
    logic glob_clr;
    logic sys_we;
    logic [N_CH-1:0] ch_stby;

    dacbank_ldsync u_ldsync (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .load_pulse (load_pulse)
    );

    assign sys_we = wr_en && (wr_sel == SEL_SYS);

    dacbank_sysctl u_sys (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_we       (sys_we),
        .sys_data     (wr_data[3:0]),
        .pwr_down     (pwr_down),
        .sys_stby     (sys_stby),
        .sys_clr_pend (sys_clr_pend),
        .twos         (twos)
    );

    assign glob_clr = hw_clear | sys_clr_pend;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_chan == CH_AW'(i));

        dacbank_chan #(
            .MAIN_W (MAIN_W),
            .TRIM_W (TRIM_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .main_we    (hit && (wr_sel == SEL_MAIN)),
            .trim_we    (hit && (wr_sel == SEL_TRIM)),
            .ctrl_we    (hit && (wr_sel == SEL_CHAN)),
            .wr_data    (wr_data),
            .load_pulse (load_pulse),
            .glob_clr   (glob_clr),
            .twos       (twos),
            .main_code  (main_code[i*MAIN_W +: MAIN_W]),
            .trim_code  (trim_code[i*TRIM_W +: TRIM_W]),
            .bias_sel   (bias_sel[i*2 +: 2]),
            .stby       (ch_stby[i])
        );
    end

    // Power enables: power-down kills everything, standby keeps the reference
    assign ref_enable = ~pwr_down;
    assign ch_enable  = (pwr_down | sys_stby) ? '0 : ~ch_stby;

    // R8: no channel runs with the reference powered down
    assert_pd_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_enable |-> (ch_enable == '0));

endmodule

// File: tb/dacbank_core_test.sv
// Bench: behavioural model updated on each rising edge, compared on each
// falling edge, plus directed checks per requirement.
module dacbank_core_test;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [1:0]  wr_sel = '0;
    logic [9:0]  wr_data = '0;
    logic        load_n = 1'b1;
    logic        hw_clear = 1'b0;
    logic [39:0] main_code;
    logic [31:0] trim_code;
    logic [7:0]  bias_sel;
    logic [3:0]  ch_enable;
    logic        ref_enable;

    int checks = 0;
    int failures = 0;
    bit compare_on = 0;
    string phase = "R1";

    dacbank_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_sel(wr_sel), .wr_data(wr_data), .load_n(load_n),
        .hw_clear(hw_clear), .main_code(main_code), .trim_code(trim_code),
        .bias_sel(bias_sel), .ch_enable(ch_enable), .ref_enable(ref_enable)
    );

    always #5 clk = ~clk;

    // Behavioural model state
    int m_data[NC], m_dac[NC], m_tdata[NC], m_tdac[NC], m_bias[NC];
    bit m_stby[NC], m_cclr[NC];
    bit m_pd, m_sstby, m_sclr, m_twos;
    bit hist[$] = '{1, 1, 1};

    function automatic void model_reset();
        for (int i = 0; i < NC; i++) begin
            m_data[i] = 'h200; m_dac[i] = 'h200; m_tdata[i] = 'h80; m_tdac[i] = 'h80;
            m_bias[i] = 0; m_stby[i] = 0; m_cclr[i] = 0;
        end
        m_pd = 0; m_sstby = 0; m_sclr = 0; m_twos = 0;
        hist = '{1, 1, 1};
    endfunction

    initial model_reset();

    // Model: next state from inputs present at this rising edge
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit pulse, sclr_old, twos_old;
            bit cclr_old[NC];
            pulse = !hist[1] && hist[2];
            hist.push_front(load_n);
            void'(hist.pop_back());
            sclr_old = m_sclr; twos_old = m_twos;
            for (int i = 0; i < NC; i++) cclr_old[i] = m_cclr[i];
            m_sclr = wr_en && wr_sel == 3 && wr_data[2];
            if (wr_en && wr_sel == 3) begin
                m_pd = wr_data[0]; m_sstby = wr_data[1]; m_twos = wr_data[3];
            end
            for (int i = 0; i < NC; i++) begin
                bit hit;
                hit = wr_en && wr_chan == i;
                m_cclr[i] = hit && wr_sel == 2 && wr_data[1];
                if (hit && wr_sel == 2) begin
                    m_stby[i] = wr_data[0];
                    if (wr_data[3:2] != 3) m_bias[i] = wr_data[3:2];
                end
                if (hw_clear || sclr_old || cclr_old[i]) begin
                    m_data[i] = twos_old ? 0 : 'h200; m_dac[i] = m_data[i];
                    m_tdata[i] = 'h80; m_tdac[i] = 'h80;
                end else begin
                    if (pulse) begin m_dac[i] = m_data[i]; m_tdac[i] = m_tdata[i]; end
                    if (hit && wr_sel == 0) m_data[i] = wr_data;
                    if (hit && wr_sel == 1) m_tdata[i] = wr_data[7:0];
                end
            end
        end
    end

    function automatic int exp_main(int i);
        return m_twos ? (m_dac[i] ^ 'h200) : m_dac[i];
    endfunction

    function automatic int exp_en();
        int v = 0;
        for (int i = 0; i < NC; i++)
            if (!m_pd && !m_sstby && !m_stby[i]) v |= (1 << i);
        return v;
    endfunction

    // Compare all outputs against the model on every falling edge
    always @(negedge clk) begin
        if (compare_on) begin
            bit bad = 0;
            for (int i = 0; i < NC; i++) begin
                if (main_code[i*10 +: 10] != exp_main(i) || trim_code[i*8 +: 8] != m_tdac[i]
                    || bias_sel[i*2 +: 2] != m_bias[i]) begin
                    bad = 1;
                    $display("FAIL %s model ch%0d main=%h/%h trim=%h/%h bias=%0d/%0d (act/exp)",
                             phase, i, main_code[i*10 +: 10], exp_main(i),
                             trim_code[i*8 +: 8], m_tdac[i], bias_sel[i*2 +: 2], m_bias[i]);
                end
            end
            if (ch_enable != exp_en() || ref_enable != !m_pd) begin
                bad = 1;
                $display("FAIL %s model en=%b/%b ref=%b/%b (act/exp)", phase,
                         ch_enable, 4'(exp_en()), ref_enable, !m_pd);
            end
            checks++;
            if (bad) failures++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input int d);
        @(negedge clk);
        wr_en = 1; wr_chan = 2'(ch); wr_sel = 2'(sel); wr_data = 10'(d);
        @(negedge clk);
        wr_en = 0;
        #1;
    endtask

    task automatic strobe_low();
        @(negedge clk); load_n = 0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic strobe_high();
        @(negedge clk); load_n = 1;
        repeat (2) @(negedge clk);
        #1;
    endtask

    function automatic int mc(int i); return int'(main_code[i*10 +: 10]); endfunction
    function automatic int tc(int i); return int'(trim_code[i*8 +: 8]); endfunction

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_on = 1;
        #1;
        phase = "R1";
        chk("R1 main ch0", mc(0), 'h200);
        chk("R1 trim ch3", tc(3), 'h80);
        chk("R1 enables", {27'd0, ref_enable, ch_enable}, 'h1F);
        chk("R1 bias", bias_sel, 0);

        phase = "R2";
        wr(1, 0, 'h155);
        wr(1, 1, 'h3A5);
        repeat (2) @(negedge clk); #1;
        chk("R2 main ch1 held", mc(1), 'h200);
        chk("R2 trim ch1 held", tc(1), 'h80);

        phase = "R3";
        strobe_low();
        chk("R3 main ch1 loaded", mc(1), 'h155);
        chk("R11 trim low bits", tc(1), 'hA5);
        chk("R3 ch0 untouched", mc(0), 'h200);
        wr(2, 0, 'h0AA);
        strobe_high();
        chk("R3 no second load", mc(2), 'h200);
        strobe_low(); strobe_high();
        chk("R3 second edge loads", mc(2), 'h0AA);

        phase = "R8";
        wr(3, 3, 'h001);
        chk("R8 ref off", ref_enable, 0);
        chk("R8 channels off", ch_enable, 0);
        wr(0, 3, 'h000);

        phase = "R9";
        wr(0, 3, 'h002);
        chk("R9 sys standby en", {ref_enable, ch_enable}, 'h10);
        wr(0, 3, 'h000);
        wr(3, 2, 'h001);
        chk("R9 ch3 standby", ch_enable, 'h7);
        wr(3, 2, 'h000);

        phase = "R10";
        wr(0, 2, 'h008);
        chk("R10 bias ext", bias_sel[1:0], 2);
        wr(0, 2, 'h00C);
        chk("R10 bias 3 ignored", bias_sel[1:0], 2);
        wr(0, 2, 'h004);
        chk("R10 bias int", bias_sel[1:0], 1);

        phase = "R7";
        wr(2, 3, 'h008);
        chk("R7 twos ch1", mc(1), 'h355);
        chk("R7 twos ch0", mc(0), 'h000);

        phase = "R6";
        wr(0, 2, 'h002);
        @(negedge clk); #1;
        chk("R6 ch0 cleared in twos", mc(0), 'h200);
        chk("R6 ch1 kept", mc(1), 'h355);
        wr(0, 3, 'h000);
        wr(0, 0, 'h011);
        strobe_low(); strobe_high();
        chk("R6 self-clear, load kept", mc(0), 'h011);

        phase = "R4";
        @(negedge clk); hw_clear = 1;
        @(negedge clk); hw_clear = 0; #1;
        chk("R4 main ch1", mc(1), 'h200);
        chk("R4 main ch2", mc(2), 'h200);
        chk("R4 trim ch1", tc(1), 'h80);

        phase = "R5";
        wr(2, 0, 'h3FF);
        strobe_low(); strobe_high();
        chk("R5 loaded before", mc(2), 'h3FF);
        wr(1, 3, 'h004);
        @(negedge clk); #1;
        chk("R5 sys clear ch2", mc(2), 'h200);
        wr(2, 0, 'h123);
        strobe_low(); strobe_high();
        chk("R5 self-clear", mc(2), 'h123);

        phase = "R12";
        @(negedge clk);
        hw_clear = 1; wr_en = 1; wr_chan = 1; wr_sel = 0; wr_data = 'h0F0;
        @(negedge clk);
        hw_clear = 0; wr_en = 0;
        strobe_low(); strobe_high();
        chk("R12 clear beats write", mc(1), 'h200);
        chk("R12 loaded ch2 cleared", mc(2), 'h200);

        compare_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired in %s", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule